// File: doc/BRIEF.md
# Stream Packet Framer with Checksum Trailer

This block sits on the transmit side of a serial link and wraps each packet taken from a 64-bit valid/ready word stream into a self-delimiting frame. A frame opens with a fixed start word and carries the packet words unchanged. It then adds a fixed end marker word and one trailer word. The trailer holds a 16-bit checksum over the packet's control (header) words, a 16-bit word count and a 32-bit checksum over the remaining words.

Both checksums and the count are built while the words flow past, so the block stores no packet data. The input is stalled only for the three words the block inserts itself. During the packet body, the output handshake passes straight through to the input. Whether the control section is one or two words long depends on a timestamp flag carried in the first header word.

Top module: `link_framer`

## Requirements
- R1: Before the first word of each packet the block offers the start word 64'h9E6774129E677412. The start word is offered only while the input offers a word, and the first packet word is not accepted until the start word has been taken.
- R2: Packet words leave in order with their data unchanged. During the packet body, input ready equals output ready and output valid equals input valid.
- R3: After the input word flagged last has been accepted, the block sends the end marker 64'h2A1D632F2A1D632F and then exactly one trailer word. outLast is high only while the trailer word is offered.
- R4: Input ready is low whenever the start word, the end marker or the trailer is being offered.
- R5: The trailer word places the control checksum in bits [63:48], the word count in bits [47:32] and the payload checksum in bits [31:0].
- R6: The word count equals the number of packet words plus one for the end marker. The start word and the trailer are not counted.
- R7: The control checksum covers packet word 0. It also covers packet word 1 when bit 61 of packet word 0 is 1.
- R8: The payload checksum covers every packet word after the control words, followed by the end marker. For a one-word packet it covers the end marker alone.
- R9: Each checksum register starts at zero when the start word is accepted. For each covered word, it processes the 64 data bits from bit 63 down to bit 0. For each bit it computes f = NOT(msb XOR bit), shifts left by one and, when f is 1, XORs in the polynomial: 0x1021 for the 16-bit checksum, 0x04C11DB7 for the 32-bit one.
- R10: While output valid is high and output ready is low, output valid stays high and the output word stays unchanged. No word is dropped or repeated.
- R11: After reset, with no input offered, output valid and input ready are both low, and the first word sent is a start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 64 | Packet word |
| inValid | input | 1 | Input word offered |
| inLast | input | 1 | Input word is the last of its packet |
| inReady | output | 1 | Input word accepted this cycle when high with inValid |
| outData | output | 64 | Framed stream word |
| outValid | output | 1 | Output word offered |
| outLast | output | 1 | Output word is the trailer |
| outReady | input | 1 | Downstream accepts the output word |

## Verification
The bench builds the block with its default parameters: a 64-bit word, a 16-bit control checksum, a 32-bit payload checksum, a 16-bit count and the timestamp flag at bit 61. Packets of one to twelve words keep every count small. They also reach the corner cases: a one-word packet with and without the flag, a two-word packet with the flag, where the payload checksum sees only the marker, and back-to-back frames that test the per-frame checksum clear. Random gaps on the input side and random stalls on the output side are applied both separately and together.

// File: rtl/link_framer_pkg.sv
package link_framer_pkg;

  typedef enum logic [1:0] {
    PH_START  = 2'd0,
    PH_BODY   = 2'd1,
    PH_MARKER = 2'd2,
    PH_TAIL   = 2'd3
  } phaseT;

  typedef struct packed {
    logic  clearFrame;
    logic  takeWord;
    logic  takeMarker;
    phaseT phase;
  } strobeT;

endpackage

// File: rtl/link_framer_crc.sv
module link_framer_crc #(
  parameter int CRC_W = 16,
  parameter int DIN_W = 64,
  parameter logic [CRC_W-1:0] POLY = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [DIN_W-1:0] din,
  output logic [CRC_W-1:0] value
);

  logic [CRC_W-1:0] nextVal;

  always_comb begin
    logic fb;
    nextVal = value;
    for (int i = DIN_W - 1; i >= 0; i--) begin
      fb = ~(nextVal[CRC_W-1] ^ din[i]);
      nextVal = {nextVal[CRC_W-2:0], 1'b0};
      if (fb) nextVal = nextVal ^ POLY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) value <= '0;
    else if (advance) value <= nextVal;
  end

endmodule

// File: rtl/link_framer_ctrl.sv
module link_framer_ctrl
  import link_framer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   outReady,
  output logic   inReady,
  output logic   outValid,
  output logic   outLast,
  output strobeT strobe
);

  phaseT phase, phaseNext;
  logic  fire;

  always_comb begin
    case (phase)
      PH_START, PH_BODY: outValid = inValid;
      default:           outValid = 1'b1;
    endcase
  end

  assign inReady = (phase == PH_BODY) && outReady;
  assign outLast = (phase == PH_TAIL);
  assign fire    = outValid && outReady;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_START:  if (fire) phaseNext = PH_BODY;
      PH_BODY:   if (fire && inLast) phaseNext = PH_MARKER;
      PH_MARKER: if (fire) phaseNext = PH_TAIL;
      PH_TAIL:   if (fire) phaseNext = PH_START;
      default:   phaseNext = PH_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_START;
    else     phase <= phaseNext;
  end

  assign strobe.clearFrame = fire && (phase == PH_START);
  assign strobe.takeWord   = fire && (phase == PH_BODY);
  assign strobe.takeMarker = fire && (phase == PH_MARKER);
  assign strobe.phase      = phase;

endmodule

// File: rtl/link_framer_dp.sv
module link_framer_dp
  import link_framer_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int CTRL_W   = 16,
  parameter int PAY_W    = 32,
  parameter int CNT_W    = 16,
  parameter int TIME_BIT = 61,
  parameter logic [CTRL_W-1:0] CTRL_POLY = 16'h1021,
  parameter logic [PAY_W-1:0]  PAY_POLY  = 32'h04C11DB7,
  parameter logic [DATA_W-1:0] PREAMBLE  = 64'h9E6774129E677412,
  parameter logic [DATA_W-1:0] MARKER    = 64'h2A1D632F2A1D632F
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  localparam int TRAIL_W = CTRL_W + CNT_W + PAY_W;

  logic [CNT_W-1:0]  wordCount;
  logic              hasTime;
  logic              ctrlAdv, payAdv;
  logic [DATA_W-1:0] payDin;
  logic [CTRL_W-1:0] ctrlSum;
  logic [PAY_W-1:0]  paySum;
  logic [TRAIL_W-1:0] trailer;

  assign ctrlAdv = strobe.takeWord &&
                   ((wordCount == '0) || ((wordCount == CNT_W'(1)) && hasTime));
  assign payAdv  = (strobe.takeWord && !ctrlAdv) || strobe.takeMarker;
  assign payDin  = strobe.takeMarker ? MARKER : inData;

  always_ff @(posedge clk) begin
    if (rst || strobe.clearFrame) begin
      wordCount <= '0;
      hasTime   <= 1'b0;
    end else begin
      if (strobe.takeWord && (wordCount == '0)) hasTime <= inData[TIME_BIT];
      if (strobe.takeWord || strobe.takeMarker) wordCount <= wordCount + 1'b1;
    end
  end

  link_framer_crc #(.CRC_W(CTRL_W), .DIN_W(DATA_W), .POLY(CTRL_POLY)) uCtrlCrc (
    .clk(clk), .rst(rst), .clear(strobe.clearFrame), .advance(ctrlAdv),
    .din(inData), .value(ctrlSum)
  );

  link_framer_crc #(.CRC_W(PAY_W), .DIN_W(DATA_W), .POLY(PAY_POLY)) uPayCrc (
    .clk(clk), .rst(rst), .clear(strobe.clearFrame), .advance(payAdv),
    .din(payDin), .value(paySum)
  );

  assign trailer = {ctrlSum, wordCount, paySum};

  always_comb begin
    case (strobe.phase)
      PH_START:  outData = PREAMBLE;
      PH_BODY:   outData = inData;
      PH_MARKER: outData = MARKER;
      default:   outData = DATA_W'(trailer);
    endcase
  end

endmodule

// File: rtl/link_framer.sv
module link_framer
  import link_framer_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int CTRL_W   = 16,
  parameter int PAY_W    = 32,
  parameter int CNT_W    = 16,
  parameter int TIME_BIT = 61,
  parameter logic [DATA_W-1:0] PREAMBLE = 64'h9E6774129E677412,
  parameter logic [DATA_W-1:0] MARKER   = 64'h2A1D632F2A1D632F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  input  logic              outReady
);

  strobeT strobe;

  link_framer_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .outLast(outLast), .strobe(strobe)
  );

  link_framer_dp #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .PAY_W(PAY_W), .CNT_W(CNT_W),
    .TIME_BIT(TIME_BIT), .PREAMBLE(PREAMBLE), .MARKER(MARKER)
  ) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .inData(inData), .outData(outData)
  );

endmodule

// File: rtl/link_framer_chk.sv
module link_framer_chk #(
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] PREAMBLE = '0,
  parameter logic [DATA_W-1:0] MARKER   = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] inData,
  input logic              inValid,
  input logic              inLast,
  input logic              inReady,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outLast,
  input logic              outReady
);

  logic expectStart;
  logic afterLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      expectStart <= 1'b1;
      afterLast   <= 1'b0;
    end else begin
      if (outValid && outReady) expectStart <= outLast;
      if (inValid && inReady && inLast) afterLast <= 1'b1;
      else if (outValid && outReady)    afterLast <= 1'b0;
    end
  end

  assert_start_word_R1: assert property (@(posedge clk) disable iff (rst)
    (outValid && expectStart) |-> (outData == PREAMBLE && !inReady));

  assert_body_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
    inReady |-> (outValid == inValid && outData == inData));

  assert_marker_follows_R3: assert property (@(posedge clk) disable iff (rst)
    afterLast |-> (outValid && outData == MARKER && !inReady && !outLast));

  assert_tail_blocks_input_R4: assert property (@(posedge clk) disable iff (rst)
    outLast |-> (outValid && !inReady));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

bind link_framer link_framer_chk #(
  .DATA_W(DATA_W), .PREAMBLE(PREAMBLE), .MARKER(MARKER)
) uChk (.*);

// File: tb/tb_link_framer.sv
module tb_link_framer;

  localparam logic [63:0] START_W  = 64'h9E6774129E677412;
  localparam logic [63:0] MARK_W   = 64'h2A1D632F2A1D632F;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] inData;
  logic        inValid, inLast, inReady;
  logic [63:0] outData;
  logic        outValid, outLast, outReady;

  always #10 clk = ~clk;

  link_framer dut (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outLast(outLast), .outReady(outReady)
  );

  typedef struct {
    logic [63:0] d;
    bit          last;
  } inWordT;

  // kind: 0 start, 1 body, 2 marker, 3 trailer
  typedef struct {
    logic [63:0] d;
    int          kind;
  } expWordT;

  inWordT  inQ[$];
  expWordT expQ[$];
  int vectors = 0;
  int misses  = 0;

  function automatic logic [63:0] refCrc(input logic [63:0] c, input int w,
                                         input logic [63:0] poly, input logic [63:0] d);
    logic [63:0] mask = (64'd1 << w) - 64'd1;
    for (int i = 63; i >= 0; i--) begin
      bit fb = !(c[w-1] ^ d[i]);
      c = (c << 1) & mask;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic addPacket(input int n, input bit stamp);
    logic [63:0] w;
    logic [63:0] cSum = 0, pSum = 0;
    int ctrlLen = stamp ? 2 : 1;
    expQ.push_back('{START_W, 0});
    for (int i = 0; i < n; i++) begin
      w = {$urandom, $urandom};
      if (i == 0) w[61] = stamp;
      inQ.push_back('{w, i == n - 1});
      expQ.push_back('{w, 1});
      if (i < ctrlLen) cSum = refCrc(cSum, 16, 64'h1021, w);
      else             pSum = refCrc(pSum, 32, 64'h04C11DB7, w);
    end
    pSum = refCrc(pSum, 32, 64'h04C11DB7, MARK_W);
    expQ.push_back('{MARK_W, 2});
    expQ.push_back('{{cSum[15:0], 16'(n + 1), pSum[31:0]}, 3});
  endtask

  task automatic runTraffic(input int pIn, input int pOut);
    int cycles = 0;
    bit held = 0;
    while (expQ.size() > 0) begin
      @(negedge clk);
      if (!held) begin
        if (inQ.size() > 0 && ($urandom % 100) < pIn) begin
          inValid = 1'b1; inData = inQ[0].d; inLast = inQ[0].last; held = 1;
        end else begin
          inValid = 1'b0; inData = {$urandom, $urandom}; inLast = $urandom;
        end
      end
      outReady = ($urandom % 100) < pOut;
      #8;
      begin
        expWordT e = expQ[0];
        bit tailKind = (e.kind >= 2);
        check("R3 R4 valid", {63'd0, outValid}, tailKind ? 64'd1 : {63'd0, inValid});
        if (outValid) begin
          string tag;
          case (e.kind)
            0: tag = "R1"; 1: tag = "R2"; 2: tag = "R3"; default: tag = "R5";
          endcase
          if (!outReady) tag = {tag, " R10"};
          if (e.kind == 3) begin
            check("R7 R9 control checksum", {48'd0, outData[63:48]}, {48'd0, e.d[63:48]});
            check("R6 word count", {48'd0, outData[47:32]}, {48'd0, e.d[47:32]});
            check("R8 R9 payload checksum", {32'd0, outData[31:0]}, {32'd0, e.d[31:0]});
          end
          check(tag, outData, e.d);
          check("R3 last flag", {63'd0, outLast}, {63'd0, e.kind == 3});
          check("R2 R4 input ready", {63'd0, inReady}, {63'd0, (e.kind == 1) && outReady});
          if (outReady) void'(expQ.pop_front());
        end
      end
      if (inValid && inReady) begin
        void'(inQ.pop_front());
        held = 0;
      end
      cycles++;
      if (cycles > 150000) begin
        misses++;
        $display("FAIL watchdog: actual %0d cycles expected drain", cycles);
        expQ.delete();
        inQ.delete();
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inLast = 1'b0; inData = '0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #8;
    check("R11 valid after reset", {63'd0, outValid}, 64'd0);
    check("R11 ready after reset", {63'd0, inReady}, 64'd0);

    // R7 R8: one-word packets with and without flag, two-word flagged packet
    addPacket(1, 0);
    addPacket(1, 1);
    addPacket(2, 1);
    addPacket(2, 0);
    addPacket(3, 0);
    addPacket(5, 1);
    runTraffic(100, 100);

    for (int k = 0; k < 12; k++) addPacket(1 + ($urandom % 12), $urandom);
    runTraffic(40, 100);
    for (int k = 0; k < 12; k++) addPacket(1 + ($urandom % 12), $urandom);
    runTraffic(100, 40);
    for (int k = 0; k < 20; k++) addPacket(1 + ($urandom % 12), $urandom);
    runTraffic(50, 50);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule